// File: doc/BRIEF.md
# Register Scoreboard Issue Interlock

This block decides, every cycle, whether the instruction held at the decode stage of an in-order processor may issue. It keeps one pending bit per architectural register and one busy flag for each long-latency execution unit. There are three tracked units: a load/store unit, an FP multiply pipeline and an FP add/subtract/convert/divide pipeline. A fourth unit code stands for single-cycle integer work, which is never tracked. An instruction is held back only for a true register conflict or for a unit that still has an operation in flight. Work sent to other units keeps issuing for as long as a slow operation stays outstanding.

At issue the block marks the destination register pending and the target unit busy. Each tracked unit has its own write-back port, a valid strobe plus a register index. A strobe clears that unit's busy flag and the pending bit of the register it names. A cache or translation miss shows up here only as a later write-back strobe; the block needs no other signal for it. A strobe in the same cycle as the check counts at once, so a waiting instruction can issue in the cycle its operand or unit is freed.

Top module: `scoreboard_interlock`

## Requirements
- R1: While reset (synchronous, active high) is asserted at a clock edge, every pending bit and every unit busy flag reads 0 after that edge.
- R2: An instruction stalls (issue 0, stall 1) in the same cycle if a source it uses (use flag 1) names a nonzero register whose pending bit is set and that no write-back strobe clears in that cycle.
- R3: An instruction that writes a register (has_dst 1) stalls in the same cycle if its nonzero destination is pending and no write-back strobe clears it in that cycle.
- R4: Unit codes are 0 = load/store, 1 = FP multiply, 2 = FP add/sub/convert/divide, 3 = integer (untracked). An instruction for a tracked unit whose busy flag is set stalls, unless that unit's write-back strobe is high in the same cycle.
- R5: Busy flags are independent. An instruction with no register conflict issues while any other unit is busy, and code 3 never stalls on a busy flag, for any number of cycles.
- R6: On an issue to a tracked unit, that unit's busy flag reads 1 after the next clock edge. If has_dst is 1 and the destination is nonzero, that register's pending bit reads 1 after the same edge. Code 3 instructions and destination 0 change no pending bit.
- R7: A write-back strobe on port k clears busy flag k and the pending bit of the register on port k's index, both visible after the next edge. An index of 0 leaves every pending bit unchanged. Pending bit 0 always reads 0.
- R8: A write-back strobe that clears a blocking register or unit lets a waiting instruction issue in that same cycle.
- R9: A source whose use flag is 0 never causes a stall, whatever its index.
- R10: With decode valid low, issue and stall are both 0 and no state changes. With decode valid high, exactly one of issue and stall is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | An instruction is present at decode |
| dec_unit | input | 2 | Target unit code (0 load/store, 1 FP mul, 2 FP add, 3 integer) |
| dec_src_a | input | 5 | First source register index |
| dec_use_a | input | 1 | First source is read |
| dec_src_b | input | 5 | Second source register index |
| dec_use_b | input | 1 | Second source is read |
| dec_dst | input | 5 | Destination register index |
| dec_has_dst | input | 1 | Instruction writes a destination |
| wb_valid | input | 3 | Write-back strobe, one bit per tracked unit |
| wb_reg | input | 15 | Write-back register index, 5 bits per unit, unit k at bits [5k+4:5k] |
| issue | output | 1 | Instruction issues this cycle |
| stall | output | 1 | Instruction is held this cycle |
| pending | output | 32 | Pending bit for each register |
| unit_busy | output | 3 | Busy flag for each tracked unit |

## Verification
The issue and stall decisions are combinational and due in the cycle the decode and write-back inputs are applied. The bench drives those inputs just after a falling edge and samples issue and stall one nanosecond later, before the next rising edge. Pending bits and busy flags pass through one register, so an issue or a strobe is seen in them only after the following rising edge. The bench reads them at the next falling edge, after setting the decode and write-back inputs back to idle so that no later stimulus overlaps.

// File: rtl/sb_pkg.sv
package sb_pkg;
  // Unit codes: values below the tracked count name a unit with a busy flag,
  // the remaining code is single-cycle integer work.
  localparam int unsigned UNIT_LSU  = 0;
  localparam int unsigned UNIT_FMUL = 1;
  localparam int unsigned UNIT_FADD = 2;
  localparam int unsigned UNIT_INT  = 3;

  typedef struct packed {
    logic raw_a;
    logic raw_b;
    logic waw;
    logic unit_conflict;
  } hazard_t;
endpackage

// File: rtl/sb_pending_file.sv
module sb_pending_file #(
  parameter int NREG  = 32,
  parameter int NUNIT = 3,
  localparam int AW = $clog2(NREG)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUNIT-1:0]      wb_valid,
  input  logic [NUNIT*AW-1:0]   wb_reg,
  input  logic                  set_en,
  input  logic [AW-1:0]         set_idx,
  output logic [NREG-1:0]       clear_mask,
  output logic [NREG-1:0]       set_mask,
  output logic [NREG-1:0]       pending
);
  // One-hot decode of a register index; register 0 maps to no bit.
  function automatic logic [NREG-1:0] reg_mask(input logic [AW-1:0] idx);
    logic [NREG-1:0] m;
    m = '0;
    if (idx != '0) m[idx] = 1'b1;
    return m;
  endfunction

  always_comb begin
    clear_mask = '0;
    for (int k = 0; k < NUNIT; k++) begin
      if (wb_valid[k]) clear_mask = clear_mask | reg_mask(wb_reg[k*AW +: AW]);
    end
  end

  assign set_mask = set_en ? reg_mask(set_idx) : '0;

  generate
    for (genvar r = 0; r < NREG; r++) begin : g_bit
      if (r == 0) begin : g_zero
        assign pending[r] = 1'b0;
      end else begin : g_flop
        logic q;
        always_ff @(posedge clk) begin
          if (rst)              q <= 1'b0;
          else if (set_mask[r]) q <= 1'b1;
          else if (clear_mask[r]) q <= 1'b0;
        end
        assign pending[r] = q;
      end
    end
  endgenerate
endmodule

// File: rtl/sb_unit_tracker.sv
module sb_unit_tracker #(
  parameter int NUNIT = 3,
  localparam int UW = $clog2(NUNIT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NUNIT-1:0] wb_valid,
  input  logic             issue,
  input  logic [UW-1:0]    unit,
  output logic [NUNIT-1:0] busy_set,
  output logic [NUNIT-1:0] unit_busy
);
  // One-hot decode of a unit code; untracked codes map to no bit.
  function automatic logic [NUNIT-1:0] unit_mask(input logic [UW-1:0] code);
    logic [NUNIT-1:0] m;
    m = '0;
    for (int k = 0; k < NUNIT; k++) begin
      if (code == UW'(k)) m[k] = 1'b1;
    end
    return m;
  endfunction

  assign busy_set = issue ? unit_mask(unit) : '0;

  generate
    for (genvar k = 0; k < NUNIT; k++) begin : g_unit
      logic q;
      always_ff @(posedge clk) begin
        if (rst)              q <= 1'b0;
        else if (busy_set[k]) q <= 1'b1;
        else if (wb_valid[k]) q <= 1'b0;
      end
      assign unit_busy[k] = q;
    end
  endgenerate
endmodule

// File: rtl/sb_hazard_check.sv
module sb_hazard_check
  import sb_pkg::*;
#(
  parameter int NREG  = 32,
  parameter int NUNIT = 3,
  localparam int AW = $clog2(NREG),
  localparam int UW = $clog2(NUNIT + 1)
) (
  input  logic [NREG-1:0]  pending,
  input  logic [NREG-1:0]  clear_mask,
  input  logic [NUNIT-1:0] unit_busy,
  input  logic [NUNIT-1:0] wb_valid,
  input  logic [UW-1:0]    unit,
  input  logic [AW-1:0]    src_a,
  input  logic             use_a,
  input  logic [AW-1:0]    src_b,
  input  logic             use_b,
  input  logic [AW-1:0]    dst,
  input  logic             has_dst,
  output hazard_t          hz,
  output logic             blocked
);
  logic [NREG-1:0]  pend_eff;
  logic [NUNIT-1:0] busy_eff;

  // A same-cycle write-back counts as already done.
  assign pend_eff = pending & ~clear_mask;
  assign busy_eff = unit_busy & ~wb_valid;

  function automatic logic reg_hit(input logic [NREG-1:0] vec,
                                   input logic [AW-1:0] idx,
                                   input logic en);
    return en && (idx != '0) && vec[idx];
  endfunction

  function automatic logic unit_hit(input logic [NUNIT-1:0] vec,
                                    input logic [UW-1:0] code);
    logic h;
    h = 1'b0;
    for (int k = 0; k < NUNIT; k++) begin
      if (code == UW'(k) && vec[k]) h = 1'b1;
    end
    return h;
  endfunction

  assign hz.raw_a         = reg_hit(pend_eff, src_a, use_a);
  assign hz.raw_b         = reg_hit(pend_eff, src_b, use_b);
  assign hz.waw           = reg_hit(pend_eff, dst, has_dst);
  assign hz.unit_conflict = unit_hit(busy_eff, unit);
  assign blocked          = |hz;
endmodule

// File: rtl/scoreboard_interlock.sv
module scoreboard_interlock
  import sb_pkg::*;
#(
  parameter int NREG  = 32,
  parameter int NUNIT = 3,
  localparam int AW = $clog2(NREG),
  localparam int UW = $clog2(NUNIT + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                dec_valid,
  input  logic [UW-1:0]       dec_unit,
  input  logic [AW-1:0]       dec_src_a,
  input  logic                dec_use_a,
  input  logic [AW-1:0]       dec_src_b,
  input  logic                dec_use_b,
  input  logic [AW-1:0]       dec_dst,
  input  logic                dec_has_dst,
  input  logic [NUNIT-1:0]    wb_valid,
  input  logic [NUNIT*AW-1:0] wb_reg,
  output logic                issue,
  output logic                stall,
  output logic [NREG-1:0]     pending,
  output logic [NUNIT-1:0]    unit_busy
);
  hazard_t         hz;
  logic            blocked;
  logic [NREG-1:0] clear_mask;
  logic [NREG-1:0] set_mask;
  logic [NUNIT-1:0] busy_set;
  logic            tracked;
  logic            pend_set_en;

  function automatic logic is_tracked(input logic [UW-1:0] code);
    return code < UW'(NUNIT);
  endfunction

  assign tracked     = is_tracked(dec_unit);
  assign issue       = dec_valid && !blocked;
  assign stall       = dec_valid && blocked;
  assign pend_set_en = issue && tracked && dec_has_dst;

  sb_hazard_check #(.NREG(NREG), .NUNIT(NUNIT)) u_hazard (
    .pending    (pending),
    .clear_mask (clear_mask),
    .unit_busy  (unit_busy),
    .wb_valid   (wb_valid),
    .unit       (dec_unit),
    .src_a      (dec_src_a),
    .use_a      (dec_use_a),
    .src_b      (dec_src_b),
    .use_b      (dec_use_b),
    .dst        (dec_dst),
    .has_dst    (dec_has_dst),
    .hz         (hz),
    .blocked    (blocked)
  );

  sb_pending_file #(.NREG(NREG), .NUNIT(NUNIT)) u_pending (
    .clk        (clk),
    .rst        (rst),
    .wb_valid   (wb_valid),
    .wb_reg     (wb_reg),
    .set_en     (pend_set_en),
    .set_idx    (dec_dst),
    .clear_mask (clear_mask),
    .set_mask   (set_mask),
    .pending    (pending)
  );

  sb_unit_tracker #(.NUNIT(NUNIT)) u_units (
    .clk        (clk),
    .rst        (rst),
    .wb_valid   (wb_valid),
    .issue      (issue),
    .unit       (dec_unit),
    .busy_set   (busy_set),
    .unit_busy  (unit_busy)
  );
endmodule

// File: rtl/sb_interlock_checker.sv
module sb_interlock_checker #(
  parameter int NREG  = 32,
  parameter int NUNIT = 3,
  localparam int AW = $clog2(NREG),
  localparam int UW = $clog2(NUNIT + 1)
) (
  input logic                clk,
  input logic                rst,
  input logic                dec_valid,
  input logic [UW-1:0]       dec_unit,
  input logic [AW-1:0]       dec_src_a,
  input logic                dec_use_a,
  input logic [AW-1:0]       dec_dst,
  input logic                dec_has_dst,
  input logic [NUNIT-1:0]    wb_valid,
  input logic                issue,
  input logic                stall,
  input logic [NREG-1:0]     pending,
  input logic [NUNIT-1:0]    unit_busy,
  input logic [NREG-1:0]     clear_mask,
  input logic [NUNIT-1:0]    busy_set
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (pending == '0 && unit_busy == '0));

  p_raw_stall_r2: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_use_a && dec_src_a != '0 && pending[dec_src_a]
     && !clear_mask[dec_src_a]) |-> (stall && !issue));

  p_waw_stall_r3: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_has_dst && dec_dst != '0 && pending[dec_dst]
     && !clear_mask[dec_dst]) |-> !issue);

  p_set_pending_r6: assert property (@(posedge clk) disable iff (rst)
    (issue && dec_has_dst && dec_dst != '0 && dec_unit < UW'(NUNIT))
    |=> pending[$past(dec_dst)]);

  p_one_unit_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(busy_set));

  p_reg0_r7: assert property (@(posedge clk) disable iff (rst)
    !pending[0]);

  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |-> (!issue && !stall));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!dec_valid && wb_valid == '0) |=> ($stable(pending) && $stable(unit_busy)));

  generate
    for (genvar k = 0; k < NUNIT; k++) begin : g_unit_chk
      p_busy_stall_r4: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_unit == UW'(k) && unit_busy[k] && !wb_valid[k])
        |-> !issue);

      p_busy_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (wb_valid[k] && !(issue && dec_unit == UW'(k))) |=> !unit_busy[k]);
    end
  endgenerate
endmodule

bind scoreboard_interlock sb_interlock_checker #(.NREG(NREG), .NUNIT(NUNIT)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .dec_valid   (dec_valid),
  .dec_unit    (dec_unit),
  .dec_src_a   (dec_src_a),
  .dec_use_a   (dec_use_a),
  .dec_dst     (dec_dst),
  .dec_has_dst (dec_has_dst),
  .wb_valid    (wb_valid),
  .issue       (issue),
  .stall       (stall),
  .pending     (pending),
  .unit_busy   (unit_busy),
  .clear_mask  (clear_mask),
  .busy_set    (busy_set)
);

// File: tb/scoreboard_interlock_bench.sv
module scoreboard_interlock_bench;
  localparam int NREG = 32;
  localparam int NUNIT = 3;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dec_valid = 1'b0;
  logic [1:0] dec_unit = '0;
  logic [AW-1:0] dec_src_a = '0, dec_src_b = '0, dec_dst = '0;
  logic dec_use_a = 1'b0, dec_use_b = 1'b0, dec_has_dst = 1'b0;
  logic [NUNIT-1:0] wb_valid = '0;
  logic [NUNIT*AW-1:0] wb_reg = '0;
  logic issue, stall;
  logic [NREG-1:0] pending;
  logic [NUNIT-1:0] unit_busy;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  scoreboard_interlock u_scoreboard_interlock (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_unit(dec_unit),
    .dec_src_a(dec_src_a), .dec_use_a(dec_use_a), .dec_src_b(dec_src_b),
    .dec_use_b(dec_use_b), .dec_dst(dec_dst), .dec_has_dst(dec_has_dst),
    .wb_valid(wb_valid), .wb_reg(wb_reg), .issue(issue), .stall(stall),
    .pending(pending), .unit_busy(unit_busy)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Apply decode fields just after a falling edge; results due 1 ns later.
  task automatic put(input logic [1:0] u, input logic [4:0] a, input logic ua,
                     input logic [4:0] b, input logic ub,
                     input logic [4:0] d, input logic hd);
    dec_valid = 1'b1; dec_unit = u; dec_src_a = a; dec_use_a = ua;
    dec_src_b = b; dec_use_b = ub; dec_dst = d; dec_has_dst = hd;
    #1;
  endtask

  task automatic wb(input int k, input logic [4:0] r);
    wb_valid[k] = 1'b1;
    wb_reg[k*AW +: AW] = r;
  endtask

  // Let one rising edge pass, then return everything to idle.
  task automatic tick();
    @(negedge clk);
    dec_valid = 1'b0; dec_use_a = 1'b0; dec_use_b = 1'b0; dec_has_dst = 1'b0;
    wb_valid = '0;
    #1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0; #1;
    check("R1 pending after reset", pending, 0);
    check("R1 busy after reset", unit_busy, 0);
    check("R10 idle issue", issue, 0);
    check("R10 idle stall", stall, 0);
    tick();
    check("R10 idle holds pending", pending, 0);
  endtask

  task automatic t_load_flow();
    put(0, 1, 1, 2, 1, 5, 1);                     // load r5
    check("R6 load issues", issue, 1);
    tick();
    check("R6 load sets r5 pending", pending, 64'h20);
    check("R6 load sets lsu busy", unit_busy, 3'b001);
    put(3, 5, 1, 0, 0, 6, 1);
    check("R2 read of pending r5 stalls", {issue, stall}, 2'b01);
    put(3, 1, 1, 5, 1, 6, 1);
    check("R2 second source r5 stalls", stall, 1);
    put(3, 5, 0, 5, 0, 6, 1);
    check("R9 unused sources ignored", issue, 1);
    tick();
    check("R6 integer sets no pending", pending, 64'h20);
    for (int i = 0; i < 25; i++) begin
      put(3, 6, 1, 7, 1, 9, 1);
      check("R5 integer keeps issuing under load", issue, 1);
      tick();
    end
    put(0, 2, 1, 0, 0, 7, 1);
    check("R4 second load stalls", stall, 1);
    put(1, 2, 1, 3, 1, 8, 1);                     // fmul r8 while load busy
    check("R5 fmul issues while lsu busy", issue, 1);
    tick();
    check("R6 fmul busy", unit_busy, 3'b011);
    check("R6 r8 pending", pending, 64'h120);
    put(3, 5, 1, 0, 0, 10, 1);
    wb(0, 5); #1;
    check("R8 same-cycle wb lets dependent issue", issue, 1);
    tick();
    check("R7 wb clears r5 and lsu", {pending, unit_busy}, {32'h100, 3'b010});
  endtask

  task automatic t_fmul_flow();
    put(1, 0, 0, 0, 0, 11, 1);
    check("R4 second fmul stalls", stall, 1);
    put(3, 0, 0, 0, 0, 8, 1);
    check("R3 write to pending r8 stalls", stall, 1);
    put(2, 1, 1, 2, 1, 12, 1);
    check("R5 fadd issues while fmul busy", issue, 1);
    tick();
    check("R6 fadd busy", unit_busy, 3'b110);
    put(1, 0, 0, 0, 0, 11, 1);
    wb(1, 8); #1;
    check("R8 fmul reissues on same-cycle wb", issue, 1);
    tick();
    check("R6 fmul busy kept on reissue", unit_busy, 3'b110);
    check("R7 r8 cleared r11 set", pending, 64'h1800);
    wb(1, 11); wb(2, 12); #1;
    tick();
    check("R7 both wb clear", {pending, unit_busy}, {32'h0, 3'b000});
  endtask

  task automatic t_reg0();
    put(0, 0, 0, 0, 0, 0, 1);
    check("R6 load to r0 issues", issue, 1);
    tick();
    check("R6 r0 never pending", pending, 0);
    check("R6 lsu busy for r0 load", unit_busy, 3'b001);
    put(2, 0, 0, 0, 0, 4, 1);
    tick();
    check("R6 r4 pending", pending, 64'h10);
    wb(0, 0); #1;
    tick();
    check("R7 wb to r0 clears lsu only", {pending, unit_busy}, {32'h10, 3'b100});
    put(3, 0, 1, 0, 1, 0, 1);
    check("R2 r0 sources never stall", issue, 1);
    tick();
    wb(2, 4); #1;
    tick();
    check("R7 r4 cleared", pending, 0);
    rst = 1'b1;
    put(1, 0, 0, 0, 0, 3, 1);
    tick();
    rst = 1'b0; #1;
    check("R1 reset wins over issue", {pending, unit_busy}, {32'h0, 3'b000});
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_load_flow();
    t_fmul_flow();
    t_reg0();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule